// File: doc/BRIEF.md
# Coarse-Fine Tuning PWM DAC

This block turns a 14-bit tuning word into a single pulse-width modulated pin that an external low-pass filter smooths into a tuning voltage. The input clock is divided by three into a tick. A 14-bit tick counter splits into a 7-bit position inside a subperiod of 128 ticks and a 7-bit subperiod index. A full repetition period is 128 subperiods. The upper 7 bits of the word (the coarse field) give a pulse at the end of every subperiod. The lower 7 bits (the fine field) add one-tick pulses at the start of a sparse, evenly spread set of subperiods, so the filtered level moves in steps of 1/16384 of full scale.

Software writes the coarse field and the fine field through two write strobes that share one data bus. A fine-field write captures the current coarse latch together with the new fine value. The captured pair moves into the working register at the next subperiod boundary, so a pattern is never switched in the middle of a subperiod. Software writes the coarse field first, then the fine field. A polarity input inverts the PWM level, and a select input hands the pin over to a plain port data bit.

Top module: `tuning_pwm_dac`

## Requirements
- R1: One tick lasts 3 input clocks. A subperiod is 128 ticks (384 clocks), and the full period is 128 subperiods (49152 clocks).
- R2: With a coarse field H, each subperiod holds the PWM level low for its first 127−H ticks and high for the remaining H+1 ticks.
- R3: A fine pulse is high for exactly tick 0 of a selected subperiod and is ORed with the coarse level, so it is one tick (3 clocks) wide.
- R4: Fine field bit k (k = 0..6), when 0, selects every subperiod whose index is an odd multiple of 2^(6−k): bit 0 selects 64, bit 6 selects all odd indices. Several zero bits select the union of their sets. Subperiod 0 is never selected, and a fine field of 7'h7F selects none.
- R5: A coarse write (wrHigh) on its own changes only the coarse latch and never starts a transfer.
- R6: A fine write (wrLow) captures the coarse latch value of that cycle together with wrData. At the first subperiod start after the write, the captured pair becomes the working register. A coarse write made after the fine write does not affect that transfer.
- R7: With pwmSel = 1, pinOut is the PWM level XOR invertOut.
- R8: With pwmSel = 0, pinOut follows portBit one clock later, whatever invertOut is.
- R9: Reset (rstN low, asynchronous) clears the divider, the counter, the latches and the working register, and drives pinOut low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrHigh | input | 1 | Write strobe for the coarse latch |
| wrLow | input | 1 | Write strobe for the fine field; arms a transfer |
| wrData | input | FIELD_W (7) | Write data for either field |
| invertOut | input | 1 | 1 inverts the PWM level |
| pwmSel | input | 1 | 1 selects PWM on the pin, 0 selects portBit |
| portBit | input | 1 | Plain port data for the shared pin |
| pinOut | output | 1 | Registered pin level |

## Verification
pinOut is registered, so a change on invertOut, pwmSel or portBit is due one clock later. The bench samples it two falling edges after the change. A fine write takes effect at the next subperiod boundary, up to 384 clocks later. The bench aligns to a boundary on the falling edge of a known pattern, samples 200 clocks in, where the old pattern must still be running, and samples again 384 clocks later, inside the next subperiod. Duty checks wait 800 clocks, which covers any pending transfer, and then count high clocks over any window of exactly 49152 clocks. Because the pattern is periodic, the window needs no alignment.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic tickAdv;   // counter advances this clock
    logic loadWork;  // staged pair moves to working register
    logic takeHigh;  // coarse latch write
    logic takeLow;   // fine write, captures pair
  } tpdStrobe_t;
endpackage

// File: rtl/tpd_ctrl.sv
module tpd_ctrl
  import tpd_pkg::*;
#(
  parameter int DIV_RATIO = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrHigh,
  input  logic       wrLow,
  input  logic       lastTick,
  output tpdStrobe_t strobe,
  output logic       pending
);
  localparam int DIV_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_RATIO - 1);

  logic [DIV_W-1:0] divCnt;
  logic             tickAdv;

  assign tickAdv = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (tickAdv) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // a fine write arms the transfer; the boundary consumes it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (wrLow) begin
      pending <= 1'b1;
    end else if (strobe.loadWork) begin
      pending <= 1'b0;
    end
  end

  always_comb begin
    strobe.tickAdv  = tickAdv;
    strobe.loadWork = tickAdv && lastTick && pending;
    strobe.takeHigh = wrHigh;
    strobe.takeLow  = wrLow;
  end
endmodule

// File: rtl/tpd_datapath.sv
module tpd_datapath
  import tpd_pkg::*;
#(
  parameter int FIELD_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  tpdStrobe_t         strobe,
  input  logic [FIELD_W-1:0] wrData,
  input  logic               invertOut,
  input  logic               pwmSel,
  input  logic               portBit,
  output logic               lastTick,
  output logic               pinOut
);
  localparam int CNT_W = 2 * FIELD_W;

  logic [FIELD_W-1:0] hiLatch;
  logic [CNT_W-1:0]   stage;
  logic [CNT_W-1:0]   work;
  logic [CNT_W-1:0]   cnt;
  logic [FIELD_W-1:0] tick;
  logic [FIELD_W-1:0] sub;
  logic [FIELD_W-1:0] workHi;
  logic [FIELD_W-1:0] workLo;
  logic [FIELD_W-1:0] subHit;
  logic               coarseLvl;
  logic               fineLvl;
  logic               pwmLevel;

  assign tick   = cnt[FIELD_W-1:0];
  assign sub    = cnt[CNT_W-1:FIELD_W];
  assign workHi = work[CNT_W-1:FIELD_W];
  assign workLo = work[FIELD_W-1:0];
  assign lastTick = (tick == {FIELD_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiLatch <= '0;
      stage   <= '0;
    end else begin
      if (strobe.takeHigh) hiLatch <= wrData;
      if (strobe.takeLow)  stage   <= {hiLatch, wrData};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      work <= '0;
    end else begin
      if (strobe.tickAdv)  cnt  <= cnt + 1'b1;
      if (strobe.loadWork) work <= stage;
    end
  end

  // fine bit k picks sub indices with exactly (FIELD_W-1-k) trailing zeros
  for (genvar k = 0; k < FIELD_W; k++) begin : g_fineSel
    localparam int TZ = FIELD_W - 1 - k;
    localparam logic [FIELD_W-1:0] MASK = FIELD_W'((1 << (TZ + 1)) - 1);
    localparam logic [FIELD_W-1:0] LSB  = FIELD_W'(1 << TZ);
    assign subHit[k] = ((sub & MASK) == LSB);
  end

  assign coarseLvl = (tick >= ~workHi);
  assign fineLvl   = (tick == '0) && |(subHit & ~workLo);
  assign pwmLevel  = coarseLvl | fineLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinOut <= 1'b0;
    end else begin
      pinOut <= pwmSel ? (pwmLevel ^ invertOut) : portBit;
    end
  end
endmodule

// File: rtl/tuning_pwm_dac.sv
module tuning_pwm_dac
  import tpd_pkg::*;
#(
  parameter int DIV_RATIO = 3,
  parameter int FIELD_W   = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrHigh,
  input  logic               wrLow,
  input  logic [FIELD_W-1:0] wrData,
  input  logic               invertOut,
  input  logic               pwmSel,
  input  logic               portBit,
  output logic               pinOut
);
  tpdStrobe_t strobe;
  logic       pending;
  logic       lastTick;

  tpd_ctrl #(.DIV_RATIO(DIV_RATIO)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrHigh   (wrHigh),
    .wrLow    (wrLow),
    .lastTick (lastTick),
    .strobe   (strobe),
    .pending  (pending)
  );

  tpd_datapath #(.FIELD_W(FIELD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .invertOut (invertOut),
    .pwmSel    (pwmSel),
    .portBit   (portBit),
    .lastTick  (lastTick),
    .pinOut    (pinOut)
  );
endmodule

// File: rtl/tuning_pwm_dac_chk.sv
module tuning_pwm_dac_chk
  import tpd_pkg::*;
#(
  parameter int DIV_RATIO = 3
) (
  input logic       clk,
  input logic       rstN,
  input logic       pwmSel,
  input logic       portBit,
  input logic       pinOut,
  input tpdStrobe_t strobe,
  input logic       pending,
  input logic       lastTick
);
  if (DIV_RATIO > 1) begin : g_gap
    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rstN)
      strobe.tickAdv |=> !strobe.tickAdv); // R1
  end

  AST_PORT_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    !pwmSel |=> (pinOut == $past(portBit))); // R8

  AST_LOAD_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWork |-> (strobe.tickAdv && lastTick)); // R6

  AST_ARM_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeLow |=> pending); // R6

  AST_HIGH_NO_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeHigh && !strobe.takeLow && !pending) |=> !pending); // R5
endmodule

bind tuning_pwm_dac tuning_pwm_dac_chk #(.DIV_RATIO(DIV_RATIO)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pwmSel   (pwmSel),
  .portBit  (portBit),
  .pinOut   (pinOut),
  .strobe   (strobe),
  .pending  (pending),
  .lastTick (lastTick)
);

// File: tb/tuning_pwm_dac_test.sv
module tuning_pwm_dac_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic       wrHigh, wrLow;
  logic [6:0] wrData;
  logic       invertOut, pwmSel, portBit;
  logic       pinOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tuning_pwm_dac uut (
    .clk(clk), .rstN(rstN), .wrHigh(wrHigh), .wrLow(wrLow), .wrData(wrData),
    .invertOut(invertOut), .pwmSel(pwmSel), .portBit(portBit), .pinOut(pinOut)
  );

  // {coarse, fine} pairs for full-period duty checks
  localparam logic [13:0] VEC [3] = '{
    {7'd0,  7'h7F},
    {7'd64, 7'h7A},
    {7'd5,  7'h00}
  };

  function automatic int fineCount(input logic [6:0] lo);
    int n = 0;
    for (int k = 0; k < 7; k++) if (!lo[k]) n += (1 << k);
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeHigh(input logic [6:0] v);
    @(negedge clk); wrHigh = 1'b1; wrData = v;
    @(negedge clk); wrHigh = 1'b0;
  endtask

  task automatic writeLow(input logic [6:0] v);
    @(negedge clk); wrLow = 1'b1; wrData = v;
    @(negedge clk); wrLow = 1'b0;
  endtask

  task automatic loadPair(input logic [6:0] h, input logic [6:0] l);
    writeHigh(h);
    writeLow(l);
    waitClk(800);
  endtask

  // with pair (0,7F) pinOut falls once per subperiod, in tick 0
  task automatic syncBase();
    @(negedge pinOut);
    @(negedge clk);
  endtask

  task automatic highRun(output int n);
    n = 0;
    @(posedge pinOut);
    @(negedge clk);
    while (pinOut) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n1, n2, lowRun, hiCnt, expCnt;
    rstN = 1'b0; wrHigh = 1'b0; wrLow = 1'b0; wrData = '0;
    invertOut = 1'b0; pwmSel = 1'b1; portBit = 1'b0;
    waitClk(3);
    check(pinOut == 1'b0, "R9 pin low in reset", int'(pinOut), 0);
    rstN = 1'b1;
    waitClk(100);
    // cleared working word: coarse 0 keeps ticks 0..126 of subperiod 0 low
    check(pinOut == 1'b0, "R9 cleared word", int'(pinOut), 0);

    loadPair(7'd0, 7'h7F);

    // R5: coarse write alone never transfers
    syncBase();
    writeHigh(7'd127);
    waitClk(200);
    check(pinOut == 1'b0, "R5 no transfer a", int'(pinOut), 0);
    waitClk(384);
    check(pinOut == 1'b0, "R5 no transfer b", int'(pinOut), 0);
    waitClk(384);
    check(pinOut == 1'b0, "R5 no transfer c", int'(pinOut), 0);

    // R6: coarse then fine, transfer at next boundary only
    syncBase();
    writeLow(7'h7F);
    waitClk(200);
    check(pinOut == 1'b0, "R6 old pattern until boundary", int'(pinOut), 0);
    waitClk(384);
    check(pinOut == 1'b1, "R6 new pair after boundary", int'(pinOut), 1);
    loadPair(7'd0, 7'h7F);

    // R6: fine then coarse uses the old coarse value
    syncBase();
    writeLow(7'h7F);
    writeHigh(7'd127);
    waitClk(580);
    check(pinOut == 1'b0, "R6 late coarse ignored", int'(pinOut), 0);
    writeLow(7'h7F);
    waitClk(800);
    check(pinOut == 1'b1, "R6 later fine write loads", int'(pinOut), 1);
    loadPair(7'd0, 7'h7F);

    // R2 / R1: coarse 3 gives 4 high ticks out of 128
    loadPair(7'd3, 7'h7F);
    highRun(n1);
    check(n1 == 12, "R2 high run clocks", n1, 12);
    lowRun = 0;
    while (!pinOut) begin
      lowRun++;
      @(negedge clk);
    end
    check(lowRun == 372, "R2 low run clocks", lowRun, 372);
    check(n1 + lowRun == 384, "R1 subperiod clocks", n1 + lowRun, 384);

    // R3 / R4: fine bit6 clear adds tick 0 to every odd subperiod
    loadPair(7'd0, 7'h3F);
    highRun(n1);
    highRun(n2);
    check(n1 + n2 == 9, "R3 alternate run sum", n1 + n2, 9);
    check((n1 == 6) || (n2 == 6), "R4 odd subperiod pulse", (n1 > n2) ? n1 : n2, 6);

    // R7: polarity
    loadPair(7'd127, 7'h7F);
    check(pinOut == 1'b1, "R7 full coarse high", int'(pinOut), 1);
    @(negedge clk); invertOut = 1'b1;
    waitClk(2);
    check(pinOut == 1'b0, "R7 inverted", int'(pinOut), 0);

    // R8: port mode ignores polarity
    @(negedge clk); pwmSel = 1'b0; portBit = 1'b1;
    waitClk(2);
    check(pinOut == 1'b1, "R8 port one", int'(pinOut), 1);
    @(negedge clk); invertOut = 1'b0;
    waitClk(2);
    check(pinOut == 1'b1, "R8 polarity no effect", int'(pinOut), 1);
    @(negedge clk); portBit = 1'b0;
    waitClk(2);
    check(pinOut == 1'b0, "R8 port zero", int'(pinOut), 0);
    @(negedge clk); pwmSel = 1'b1;

    // R1 / R2 / R4: high clocks over one full period of 49152 clocks
    for (int i = 0; i < 3; i++) begin
      loadPair(VEC[i][13:7], VEC[i][6:0]);
      hiCnt = 0;
      repeat (49152) begin
        @(negedge clk);
        if (pinOut) hiCnt++;
      end
      expCnt = 3 * (128 * (int'(VEC[i][13:7]) + 1) + fineCount(VEC[i][6:0]));
      check(hiCnt == expCnt, "R4 period duty", hiCnt, expCnt);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule